// File: doc/BRIEF.md
# Access-ID Pulse-Position Codec

This block produces and checks the access-ID preamble that heads every frame on a phone-line home network. The preamble is a fixed number of symbols. Each symbol is a window 130 TICs long. A 2-bit value is carried by where a single pulse falls inside that window. After the last symbol there is a programmable silence interval. A transmitting station watches this interval for foreign activity.

A frame starts with a one-cycle `start`. That cycle latches the symbol values, the transmit/receive mode and three spacing counts: a lead-in before the first symbol, a guard gap between symbols, and the silence length. The timebase moves only on cycles where `tic_en` is high, so an outer divider sets the real TIC rate. In transmit mode the block emits `tx_pulse` at the encoded TIC of each window. In both modes it decodes the sampled line in every window and reports one result per symbol. In transmit mode it also raises a sticky `collision` when the line does not carry exactly what was sent, or when anything is heard during silence.

Top module: `aidpp_codec`

## Requirements
- R1: A `start` seen while idle begins a frame made of `lead_len` lead-in TICs, then NSYM windows of 130 TICs each separated by `gap_len` guard TICs, then `sil_len` silence TICs. Any of the three counts may be zero. `busy` is high from the cycle after the start until the last TIC is consumed. `frame_done` pulses for one cycle right after that. A `start` while busy has no effect.
- R2: The timebase advances one TIC only on cycles with `tic_en` high. `line_pulse` is sampled only on those cycles.
- R3: In transmit mode, symbol s takes its value c from `tx_codes[2s+1:2s]`. `tx_pulse` is high while the window's TIC count equals 66 + 20·c, giving TIC 66, 86, 106 or 126 for codes 0 to 3. In receive mode `tx_pulse` stays low.
- R4: A sampled pulse at window TIC t is accepted as code c when |t − (66 + 20·c)| ≤ 2. When a window holds exactly one accepted pulse and nothing else, `rx_valid` pulses in the cycle after its last TIC. At the same time `rx_code` carries c and `rx_index` carries the symbol number, counted from 0.
- R5: A window with no pulse, with two or more accepted pulses, or with any pulse outside every tolerance band ends with `rx_err` instead of `rx_valid`. In that case `rx_code` keeps its previous value.
- R6: Pulses during the lead-in, the guard gaps or idle time produce no result and no collision.
- R7: In transmit mode, a window whose result is not a valid decode equal to the value sent sets `collision`. `collision` stays high until the next accepted start, which clears it.
- R8: A sampled pulse during the silence interval sets `collision` in transmit mode. It has no effect in receive mode.
- R9: After reset all outputs are low and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tic_en | input | 1 | TIC strobe; timebase advances when high |
| start | input | 1 | Begin a frame (taken only when idle) |
| tx_mode | input | 1 | 1 = transmitting station, 0 = receive only |
| tx_codes | input | 2*NSYM | Symbol values, symbol s in bits [2s+1:2s] |
| lead_len | input | LENW | Lead-in TICs before the first window |
| gap_len | input | LENW | Guard TICs between windows |
| sil_len | input | LENW | Silence TICs after the last window |
| line_pulse | input | 1 | Detected line pulse |
| tx_pulse | output | 1 | Encoded transmit pulse |
| busy | output | 1 | Frame in progress |
| rx_valid | output | 1 | One-cycle flag: symbol decoded |
| rx_err | output | 1 | One-cycle flag: symbol window in error |
| rx_code | output | 2 | Last decoded symbol value |
| rx_index | output | IDXW | Number of the symbol last reported |
| collision | output | 1 | Sticky transmit collision flag |
| frame_done | output | 1 | One-cycle end-of-frame flag |

## Verification
The hardest case to reach is a window whose last TIC is consumed on the same edge that ends the frame or starts a window that opens at once. This happens with zero guard or zero silence, and with `tic_en` dropping for random stretches, so the result and the end-of-frame flag meet on one cycle. The stimulus draws spacing counts from a range that includes zero and gates `tic_en` at random. It also drives line noise on cycles without a TIC. The bench tracks which TIC each edge consumed, so every output cycle is checked against its own model, including cycles where nothing may be reported. Directed frames cover pulses exactly two and three TICs off nominal, doubled pulses, silence hits in both modes, and a restart attempt in the middle of a frame.

// File: rtl/aidpp_pkg.sv
package aidpp_pkg;

    localparam int WIN_LEN   = 130;
    localparam int POS_BASE  = 66;
    localparam int POS_STEP  = 20;
    localparam int TOL       = 2;
    localparam int TICW      = 8;
    localparam int NSYM_DEF  = 6;
    localparam int LENW_DEF  = 8;

    typedef logic [1:0] code_t;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_LEAD = 3'd1,
        PH_WIN  = 3'd2,
        PH_GAP  = 3'd3,
        PH_SIL  = 3'd4
    } phase_e;

    typedef struct packed {
        logic  hit;
        code_t code;
    } match_t;

    function automatic int pos_of(code_t c);
        return POS_BASE + POS_STEP * int'(c);
    endfunction

    function automatic match_t classify(int t);
        match_t m;
        m = '0;
        for (int c = 0; c < 4; c++) begin
            int d;
            d = t - pos_of(code_t'(c));
            if (d >= -TOL && d <= TOL) begin
                m.hit  = 1'b1;
                m.code = code_t'(c);
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/aidpp_timebase.sv
module aidpp_timebase
    import aidpp_pkg::*;
#(
    parameter int NSYM = NSYM_DEF,
    parameter int LENW = LENW_DEF,
    localparam int CNTW = (LENW > TICW) ? LENW : TICW,
    localparam int IDXW = (NSYM > 1) ? $clog2(NSYM) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tic_en,
    input  logic            start,
    input  logic [LENW-1:0] lead_len,
    input  logic [LENW-1:0] gap_len,
    input  logic [LENW-1:0] sil_len,
    output phase_e          phase,
    output logic [CNTW-1:0] tic_cnt,
    output logic [IDXW-1:0] sym_idx,
    output logic            accept,
    output logic            win_end,
    output logic            frame_done
);

    logic [LENW-1:0] lead_q, gap_q, sil_q;
    logic            lead_last, gap_last, sil_last, last_sym;

    assign accept    = (phase == PH_IDLE) && start;
    assign win_end   = (phase == PH_WIN) && tic_en && (int'(tic_cnt) == WIN_LEN - 1);
    assign lead_last = (int'(tic_cnt) + 1 == int'(lead_q));
    assign gap_last  = (int'(tic_cnt) + 1 == int'(gap_q));
    assign sil_last  = (int'(tic_cnt) + 1 == int'(sil_q));
    assign last_sym  = (int'(sym_idx) == NSYM - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            tic_cnt    <= '0;
            sym_idx    <= '0;
            lead_q     <= '0;
            gap_q      <= '0;
            sil_q      <= '0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        lead_q  <= lead_len;
                        gap_q   <= gap_len;
                        sil_q   <= sil_len;
                        tic_cnt <= '0;
                        sym_idx <= '0;
                        phase   <= (lead_len == '0) ? PH_WIN : PH_LEAD;
                    end
                end
                PH_LEAD: begin
                    if (tic_en) begin
                        if (lead_last) begin
                            phase   <= PH_WIN;
                            tic_cnt <= '0;
                        end else begin
                            tic_cnt <= tic_cnt + 1'b1;
                        end
                    end
                end
                PH_WIN: begin
                    if (tic_en) begin
                        if (int'(tic_cnt) == WIN_LEN - 1) begin
                            tic_cnt <= '0;
                            if (last_sym) begin
                                if (sil_q == '0) begin
                                    phase      <= PH_IDLE;
                                    frame_done <= 1'b1;
                                end else begin
                                    phase <= PH_SIL;
                                end
                            end else if (gap_q == '0) begin
                                sym_idx <= sym_idx + 1'b1;
                            end else begin
                                phase <= PH_GAP;
                            end
                        end else begin
                            tic_cnt <= tic_cnt + 1'b1;
                        end
                    end
                end
                PH_GAP: begin
                    if (tic_en) begin
                        if (gap_last) begin
                            phase   <= PH_WIN;
                            tic_cnt <= '0;
                            sym_idx <= sym_idx + 1'b1;
                        end else begin
                            tic_cnt <= tic_cnt + 1'b1;
                        end
                    end
                end
                PH_SIL: begin
                    if (tic_en) begin
                        if (sil_last) begin
                            phase      <= PH_IDLE;
                            tic_cnt    <= '0;
                            frame_done <= 1'b1;
                        end else begin
                            tic_cnt <= tic_cnt + 1'b1;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R2: no TIC strobe and no start leaves the timebase frozen
    a_r2_hold_without_tic: assert property (@(posedge clk) disable iff (rst)
        (!tic_en && !start) |=> ($stable(tic_cnt) && $stable(phase) && $stable(sym_idx)));

    // R1: end-of-frame flag only appears once the sequencer is idle
    a_r1_done_when_idle: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> (phase == PH_IDLE));

    // R1: a window always restarts its count after the final TIC
    a_r1_window_wrap: assert property (@(posedge clk) disable iff (rst)
        win_end |=> (tic_cnt == '0));

endmodule

// File: rtl/aidpp_tx_enc.sv
module aidpp_tx_enc
    import aidpp_pkg::*;
#(
    parameter int NSYM = NSYM_DEF,
    parameter int CNTW = TICW,
    localparam int IDXW = (NSYM > 1) ? $clog2(NSYM) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              tx_mode,
    input  logic [2*NSYM-1:0] tx_codes,
    input  phase_e            phase,
    input  logic [CNTW-1:0]   tic_cnt,
    input  logic [IDXW-1:0]   sym_idx,
    output logic              tx_active,
    output code_t             cur_code,
    output logic              tx_pulse
);

    logic [2*NSYM-1:0] codes_q;
    code_t             code_arr [NSYM];

    generate
        for (genvar g = 0; g < NSYM; g++) begin : g_unpack
            assign code_arr[g] = codes_q[2*g +: 2];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            codes_q   <= '0;
            tx_active <= 1'b0;
        end else if (accept) begin
            codes_q   <= tx_codes;
            tx_active <= tx_mode;
        end
    end

    assign cur_code = (int'(sym_idx) < NSYM) ? code_arr[sym_idx] : '0;
    assign tx_pulse = tx_active && (phase == PH_WIN) && (int'(tic_cnt) == pos_of(cur_code));

endmodule

// File: rtl/aidpp_rx_dec.sv
module aidpp_rx_dec
    import aidpp_pkg::*;
#(
    parameter int NSYM = NSYM_DEF,
    parameter int CNTW = TICW,
    localparam int IDXW = (NSYM > 1) ? $clog2(NSYM) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            tic_en,
    input  phase_e          phase,
    input  logic [CNTW-1:0] tic_cnt,
    input  logic [IDXW-1:0] sym_idx,
    input  logic            win_end,
    input  logic            line_pulse,
    input  logic            tx_active,
    input  code_t           sent_code,
    output logic            rx_valid,
    output logic            rx_err,
    output code_t           rx_code,
    output logic [IDXW-1:0] rx_index,
    output logic            collision
);

    logic [1:0] hits, nxt_hits;
    logic       stray, nxt_stray;
    code_t      code_acc, nxt_code;
    match_t     m;
    logic       sample, take_hit, win_ok, sil_hit;

    assign sample    = tic_en && line_pulse && (phase == PH_WIN);
    assign m         = classify(int'(tic_cnt));
    assign take_hit  = sample && m.hit;
    assign nxt_hits  = (take_hit && hits != 2'd2) ? hits + 2'd1 : hits;
    assign nxt_stray = stray | (sample && !m.hit);
    assign nxt_code  = take_hit ? m.code : code_acc;
    assign win_ok    = (nxt_hits == 2'd1) && !nxt_stray;
    assign sil_hit   = tic_en && line_pulse && (phase == PH_SIL);

    always_ff @(posedge clk) begin
        if (rst) begin
            hits      <= '0;
            stray     <= 1'b0;
            code_acc  <= '0;
            rx_valid  <= 1'b0;
            rx_err    <= 1'b0;
            rx_code   <= '0;
            rx_index  <= '0;
            collision <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            rx_err   <= 1'b0;
            if (clr) begin
                hits      <= '0;
                stray     <= 1'b0;
                collision <= 1'b0;
            end else if (win_end) begin
                rx_valid <= win_ok;
                rx_err   <= !win_ok;
                rx_index <= sym_idx;
                if (win_ok) begin
                    rx_code <= nxt_code;
                end
                if (tx_active && (!win_ok || nxt_code != sent_code)) begin
                    collision <= 1'b1;
                end
                hits  <= '0;
                stray <= 1'b0;
            end else begin
                hits     <= nxt_hits;
                stray    <= nxt_stray;
                code_acc <= nxt_code;
                if (tx_active && sil_hit) begin
                    collision <= 1'b1;
                end
            end
        end
    end

    // R5: a window yields either a decode or an error, never both
    a_r5_one_outcome: assert property (@(posedge clk) disable iff (rst)
        !(rx_valid && rx_err));

    // R4: results only follow a TIC consumed inside a window
    a_r4_after_window: assert property (@(posedge clk) disable iff (rst)
        (rx_valid || rx_err) |-> $past(phase == PH_WIN && tic_en));

    // R5: an error window leaves the held value alone
    a_r5_code_kept: assert property (@(posedge clk) disable iff (rst)
        rx_err |-> $stable(rx_code));

    // R7: collision is sticky until a new frame is accepted
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        (collision && !clr) |=> collision);

    // R8: a receive-only frame never raises collision
    a_r8_tx_only: assert property (@(posedge clk) disable iff (rst)
        $rose(collision) |-> $past(tx_active));

endmodule

// File: rtl/aidpp_codec.sv
module aidpp_codec
    import aidpp_pkg::*;
#(
    parameter int NSYM = NSYM_DEF,
    parameter int LENW = LENW_DEF,
    localparam int CNTW = (LENW > TICW) ? LENW : TICW,
    localparam int IDXW = (NSYM > 1) ? $clog2(NSYM) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tic_en,
    input  logic              start,
    input  logic              tx_mode,
    input  logic [2*NSYM-1:0] tx_codes,
    input  logic [LENW-1:0]   lead_len,
    input  logic [LENW-1:0]   gap_len,
    input  logic [LENW-1:0]   sil_len,
    input  logic              line_pulse,
    output logic              tx_pulse,
    output logic              busy,
    output logic              rx_valid,
    output logic              rx_err,
    output logic [1:0]        rx_code,
    output logic [IDXW-1:0]   rx_index,
    output logic              collision,
    output logic              frame_done
);

    phase_e          phase;
    logic [CNTW-1:0] tic_cnt;
    logic [IDXW-1:0] sym_idx;
    logic            accept, win_end, tx_active;
    code_t           cur_code;

    aidpp_timebase #(.NSYM(NSYM), .LENW(LENW)) u_tb (
        .clk(clk), .rst(rst), .tic_en(tic_en), .start(start),
        .lead_len(lead_len), .gap_len(gap_len), .sil_len(sil_len),
        .phase(phase), .tic_cnt(tic_cnt), .sym_idx(sym_idx),
        .accept(accept), .win_end(win_end), .frame_done(frame_done)
    );

    aidpp_tx_enc #(.NSYM(NSYM), .CNTW(CNTW)) u_enc (
        .clk(clk), .rst(rst), .accept(accept), .tx_mode(tx_mode),
        .tx_codes(tx_codes), .phase(phase), .tic_cnt(tic_cnt),
        .sym_idx(sym_idx), .tx_active(tx_active), .cur_code(cur_code),
        .tx_pulse(tx_pulse)
    );

    aidpp_rx_dec #(.NSYM(NSYM), .CNTW(CNTW)) u_dec (
        .clk(clk), .rst(rst), .clr(accept), .tic_en(tic_en), .phase(phase),
        .tic_cnt(tic_cnt), .sym_idx(sym_idx), .win_end(win_end),
        .line_pulse(line_pulse), .tx_active(tx_active), .sent_code(cur_code),
        .rx_valid(rx_valid), .rx_err(rx_err), .rx_code(rx_code),
        .rx_index(rx_index), .collision(collision)
    );

    assign busy = (phase != PH_IDLE);

    // R3: an encoded pulse lasts exactly one TIC
    a_r3_single_tic: assert property (@(posedge clk) disable iff (rst)
        (tx_pulse && tic_en) |=> !tx_pulse);

    // R1: a start while busy does not disturb the running frame
    a_r1_busy_start: assert property (@(posedge clk) disable iff (rst)
        (start && busy && !tic_en) |=> busy);

    // R9: nothing is reported while idle
    a_r9_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy)) |-> (!rx_valid && !rx_err && !tx_pulse));

endmodule

// File: tb/aidpp_codec_tb.sv
module aidpp_codec_tb;

    localparam int NSYM  = 6;
    localparam int LENW  = 8;
    localparam int IDXW  = 3;
    localparam int WIN   = 130;
    localparam int LIMIT = 190000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tic_en = 1'b0, start = 1'b0, tx_mode = 1'b0, line_pulse = 1'b0;
    logic [2*NSYM-1:0] tx_codes = '0;
    logic [LENW-1:0] lead_len = '0, gap_len = '0, sil_len = '0;
    logic tx_pulse, busy, rx_valid, rx_err, collision, frame_done;
    logic [1:0] rx_code;
    logic [IDXW-1:0] rx_index;

    int checks = 0, errors = 0, cycles = 0;
    int fL, fG, fS, fmode, fen, frestart, fsil, fxtra;
    int codes [NSYM];
    int pa [NSYM];
    int pb [NSYM];
    int lastc = 0;

    always #2 clk = ~clk;

    aidpp_codec #(.NSYM(NSYM), .LENW(LENW)) u_dut (
        .clk(clk), .rst(rst), .tic_en(tic_en), .start(start), .tx_mode(tx_mode),
        .tx_codes(tx_codes), .lead_len(lead_len), .gap_len(gap_len),
        .sil_len(sil_len), .line_pulse(line_pulse), .tx_pulse(tx_pulse),
        .busy(busy), .rx_valid(rx_valid), .rx_err(rx_err), .rx_code(rx_code),
        .rx_index(rx_index), .collision(collision), .frame_done(frame_done)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > LIMIT) begin
            errors++;
            $display("FAIL R1 watchdog expired: actual %0d cycles expected < %0d", cycles, LIMIT);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int pos(int c);
        return 66 + 20 * c;
    endfunction

    function automatic int match_code(int t);
        for (int c = 0; c < 4; c++) begin
            if (t - pos(c) >= -2 && t - pos(c) <= 2) return c;
        end
        return -1;
    endfunction

    function automatic bit win_ok(int s);
        int ha, hb;
        ha = (pa[s] >= 0) ? match_code(pa[s]) : -2;
        hb = (pb[s] >= 0) ? match_code(pb[s]) : -2;
        if (ha == -1 || hb == -1) return 0;
        return (ha >= 0) != (hb >= 0);
    endfunction

    function automatic int win_code(int s);
        if (pa[s] >= 0 && match_code(pa[s]) >= 0) return match_code(pa[s]);
        return match_code(pb[s]);
    endfunction

    function automatic int sil_start();
        return fL + NSYM * WIN + (NSYM - 1) * fG;
    endfunction

    // returns window number of a tic index, -1 outside windows; r = offset
    function automatic int where(int n, output int r);
        int off;
        r = -1;
        if (n < fL || n >= sil_start()) return -1;
        off = n - fL;
        r = off % (WIN + fG);
        if (r >= WIN) return -1;
        return off / (WIN + fG);
    endfunction

    function automatic bit sched(int n);
        int s, r;
        s = where(n, r);
        if (s >= 0) return (r == pa[s]) || (r == pb[s]);
        if (n >= sil_start()) return (fsil >= 0) && (n - sil_start() == fsil);
        return n == fxtra;
    endfunction

    task automatic run_frame(input string req_coll);
        int n, pn, cyc, last, s, r;
        bit fin, en, expcoll;
        last = sil_start() + fS - 1;
        expcoll = 0;
        for (int k = 0; k < NSYM; k++) begin
            if (fmode != 0 && (!win_ok(k) || win_code(k) != codes[k])) expcoll = 1;
        end
        if (fmode != 0 && fsil >= 0) expcoll = 1;
        @(negedge clk);
        start = 1'b1; tic_en = 1'b0; line_pulse = 1'b0;
        tx_mode = (fmode != 0);
        for (int k = 0; k < NSYM; k++) tx_codes[2*k +: 2] = 2'(codes[k]);
        lead_len = LENW'(fL); gap_len = LENW'(fG); sil_len = LENW'(fS);
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R1 busy after start", int'(busy), 1);
        chk(collision == 1'b0, "R7 collision cleared by start", int'(collision), 0);
        n = 0; pn = -1; cyc = 0; fin = 0;
        while (!fin) begin
            if (pn >= 0) begin
                s = where(pn, r);
                if (s >= 0 && r == WIN - 1) begin
                    chk(rx_valid == win_ok(s), "R4 rx_valid at window end", int'(rx_valid), int'(win_ok(s)));
                    chk(rx_err == !win_ok(s), "R5 rx_err at window end", int'(rx_err), int'(!win_ok(s)));
                    chk(int'(rx_index) == s, "R4 rx_index", int'(rx_index), s);
                    if (win_ok(s)) begin
                        chk(int'(rx_code) == win_code(s), "R4 rx_code", int'(rx_code), win_code(s));
                        lastc = win_code(s);
                    end else begin
                        chk(int'(rx_code) == lastc, "R5 rx_code kept", int'(rx_code), lastc);
                    end
                end else begin
                    chk(!rx_valid && !rx_err, "R6 no result off window end", int'({rx_valid, rx_err}), 0);
                end
                if (pn == last) begin
                    chk(frame_done && !busy, "R1 frame end", int'({frame_done, busy}), 2);
                    fin = 1;
                end else begin
                    chk(!frame_done && busy, "R1 frame running", int'({frame_done, busy}), 1);
                end
            end else begin
                chk(!rx_valid && !rx_err, "R2 no result without TIC", int'({rx_valid, rx_err}), 0);
            end
            if (!fin) begin
                s = where(n, r);
                chk(tx_pulse == (fmode != 0 && s >= 0 && r == pos(codes[s])),
                    "R3 tx_pulse", int'(tx_pulse), int'(fmode != 0 && s >= 0 && r == pos(codes[s])));
                en = ($urandom_range(99) < fen);
                tic_en = en;
                line_pulse = en ? sched(n) : ($urandom_range(3) == 0);
                start = (cyc == frestart);
                @(negedge clk);
                pn = en ? n : -1;
                if (en) n++;
                cyc++;
            end
        end
        tic_en = 1'b0; line_pulse = 1'b0; start = 1'b0;
        chk(collision == expcoll, req_coll, int'(collision), int'(expcoll));
    endtask

    task automatic clear_frame(input int L, input int G, input int S, input int mode);
        fL = L; fG = G; fS = S; fmode = mode;
        fen = 100; frestart = -1; fsil = -1; fxtra = -1;
        for (int k = 0; k < NSYM; k++) begin
            codes[k] = k % 4; pa[k] = pos(k % 4); pb[k] = -1;
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk({tx_pulse, busy, rx_valid, rx_err, collision, frame_done} == 6'b0,
            "R9 reset outputs", int'({tx_pulse, busy, rx_valid, rx_err, collision, frame_done}), 0);
        chk(rx_code == 2'd0 && rx_index == '0, "R9 reset fields", int'(rx_code), 0);

        // R6: idle pulses with TIC strobe produce nothing
        tic_en = 1'b1; line_pulse = 1'b1;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk(!rx_valid && !rx_err && !busy && !collision, "R6 idle pulses ignored",
                int'({rx_valid, rx_err, busy, collision}), 0);
        end
        tic_en = 1'b0; line_pulse = 1'b0;

        // R4 clean receive
        clear_frame(3, 4, 5, 0);
        codes[0] = 0; codes[1] = 1; codes[2] = 2; codes[3] = 3; codes[4] = 3; codes[5] = 0;
        for (int k = 0; k < NSYM; k++) pa[k] = pos(codes[k]);
        run_frame("R8 receive frame no collision");

        // R4/R5 tolerance edges, empty and doubled windows
        clear_frame(2, 3, 2, 0);
        pa[0] = pos(1) + 2; pa[1] = pos(2) - 2; pa[2] = pos(0) + 3;
        pa[3] = pos(3) - 3; pa[4] = -1; pa[5] = pos(0); pb[5] = pos(2);
        run_frame("R8 receive frame no collision");

        // R6 pulses in lead-in and guard gaps, receive mode
        clear_frame(6, 6, 3, 0);
        fxtra = 2;
        run_frame("R6 lead pulse no collision");
        clear_frame(6, 6, 3, 0);
        fxtra = 6 + WIN + 2;
        run_frame("R6 gap pulse no collision");

        // R7 transmit echo with jitter: no collision
        clear_frame(4, 2, 4, 1);
        codes[0] = 3; codes[1] = 2; codes[2] = 0; codes[3] = 1; codes[4] = 1; codes[5] = 2;
        for (int k = 0; k < NSYM; k++) pa[k] = pos(codes[k]) + ((k % 2) ? 1 : -2);
        run_frame("R7 clean echo no collision");

        // R7 transmit with foreign symbol
        clear_frame(4, 2, 4, 1);
        pa[3] = pos(0);
        run_frame("R7 mismatched symbol collision");

        // R8 silence pulse, transmit then receive
        clear_frame(1, 1, 6, 1);
        fsil = 3;
        run_frame("R8 silence pulse collision in transmit");
        clear_frame(1, 1, 6, 0);
        fsil = 3;
        run_frame("R8 silence pulse ignored in receive");

        // R1 zero spacing everywhere
        clear_frame(0, 0, 0, 1);
        run_frame("R7 zero spacing clean");

        // R2 gated TIC strobe with restart attempt (R1)
        clear_frame(5, 3, 4, 1);
        fen = 45; frestart = 7;
        run_frame("R2 gated strobe collision");

        // constrained random frames
        for (int f = 0; f < 40; f++) begin
            clear_frame($urandom_range(12), $urandom_range(12), $urandom_range(12), $urandom_range(1));
            if ($urandom_range(3) == 0) fL = 0;
            if ($urandom_range(3) == 0) fG = 0;
            if ($urandom_range(3) == 0) fS = 0;
            fen = ($urandom_range(1) == 0) ? 100 : 70;
            frestart = ($urandom_range(4) == 0) ? int'($urandom_range(40)) : -1;
            fsil = (fS > 0 && $urandom_range(4) == 0) ? int'($urandom_range(fS - 1)) : -1;
            fxtra = (fL > 0 && $urandom_range(4) == 0) ? int'($urandom_range(fL - 1)) : -1;
            for (int k = 0; k < NSYM; k++) begin
                int sc, oc, jit;
                codes[k] = $urandom_range(3);
                oc = (fmode != 0) ? codes[k] : int'($urandom_range(3));
                jit = int'($urandom_range(4)) - 2;
                sc = $urandom_range(9);
                pb[k] = -1;
                if (sc <= 5) pa[k] = pos(oc) + jit;
                else if (sc == 6) pa[k] = -1;
                else if (sc == 7) begin pa[k] = pos(oc); pb[k] = pos((oc + 1) % 4); end
                else if (sc == 8) pa[k] = pos(oc) + (($urandom_range(1) == 0) ? 3 : -4);
                else pa[k] = pos((oc + 2) % 4) + jit;
            end
            run_frame(fsil >= 0 ? "R8 random collision" : "R7 random collision");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule